// File: doc/BRIEF.md
# Three-Counter Event Monitor

This block counts hardware events for a processor core. It holds a cycle counter and two counters whose event source is chosen by an 8-bit code. A 256-bit vector of single-cycle strobes carries the events, and the bit at a counter's code position is that counter's event. One 32-bit control word holds these fields:

- a global run enable;
- a slow-rate option for the cycle counter;
- two write-one clear actions;
- per-counter interrupt enables;
- per-counter overflow flags;
- the two event codes.

A two-bit register port writes the control word and the three counters, and reads them back. A read has no side effect.

The configurable counters have no individual stop bit. Software parks a counter by selecting code 0x20, and that code never produces a count. The overflow flags are write-one-to-clear, and the clear actions read back as zero. As a result, software can read the control word and write the same value back. The only effect is to acknowledge the flags that were set.

Top module: `evmon`

## Requirements
- R1: After reset, the control word, all three counters and `irq` are zero.
- R2: While control bit 0 (run) is 0, no counter changes unless the port writes it.
- R3: While run is 1, configurable counter 0 increments by one in each cycle where `ev_strobe[code0]` is 1, and counter 1 does the same with `ev_strobe[code1]`. code0 is control bits 27:20 and code1 is control bits 19:12.
- R4: A configurable counter whose code is 0x20 never increments, whatever the value of `ev_strobe[32]`.
- R5: While run is 1 and control bit 3 is 0, the cycle counter increments every cycle. While run is 1 and bit 3 is 1, it increments once every 64 cycles. A 6-bit prescaler advances on each cycle with run=1, and the count happens on the cycle where the prescaler holds 63. Writing bit 2 also clears the prescaler.
- R6: A control write with bit 1 set clears both configurable counters. A control write with bit 2 set clears the cycle counter. A clear takes priority over an increment in the same cycle, and bits 1 and 2 read as 0.
- R7: A port write to address 1 (cycle counter), 2 (counter 0) or 3 (counter 1) loads the value at the next edge. The write takes priority over an increment in the same cycle, and that cycle raises no overflow.
- R8: An increment from 0xFFFFFFFF gives 0 and sets that counter's overflow flag at the same edge.
- R9: The overflow flags are control bits 8 (counter 0), 9 (counter 1) and 10 (cycle counter). A control write with a 1 in a flag bit clears that flag and a 0 leaves it alone. A wrap in the same cycle sets the flag anyway.
- R10: `irq` is 1 exactly when some overflow flag is set and its interrupt enable is set. The enables are control bit 4 (counter 0), bit 5 (counter 1) and bit 6 (cycle counter).
- R11: The read address map is: 0 for control, 1 for the cycle counter, 2 for counter 0 and 3 for counter 1. Control bits 1, 2, 7, 11 and 31:28 read as 0.
- R12: Writing back the control word just read changes nothing except clearing the flags that were set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_strobe | input | 256 | Event strobes, indexed by event code |
| irq | output | 1 | Shared overflow interrupt |

## Verification
Read data is combinational, so `bus_rdata` shows a register's value during the same cycle the address is presented. Any write, clear, increment or wrap shows up in the cycle after the rising edge that applied it. `irq` follows a flag in the same cycle the flag appears. The bench drives all inputs just after the falling edge. It compares `bus_rdata` and `irq` 1 ns later against a bench model that advances only on the rising edge. The model also counts the 64-cycle divided rate edge by edge, so the boundary checks land exactly one edge before and one edge at the count.

// File: rtl/evmon.sv
module evmon #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 6,
  parameter logic [7:0] PARK = 8'h20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [255:0] ev_strobe,
  output logic        irq
);
  localparam int EV_W = 8;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [PRE_W-1:0] PONE = PRE_W'(1);

  logic                  en_q, div_q;
  logic [2:0]            ie_q, ovf_q;
  logic [1:0][EV_W-1:0]  sel_q;
  logic [1:0][CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0]      cyc_q;
  logic [PRE_W-1:0]      pre_q;
  logic [1:0]            hit, ld, wrap;
  logic                  cyc_wrap;

  wire ctl_wr   = bus_wr && (bus_addr == 2'd0);
  wire cyc_ld   = bus_wr && (bus_addr == 2'd1);
  wire clr_pair = ctl_wr && bus_wdata[1];
  wire clr_cyc  = ctl_wr && bus_wdata[2];
  wire tick     = en_q && (!div_q || (&pre_q));

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      ld[i]   = bus_wr && (bus_addr == 2'(2 + i));
      hit[i]  = en_q && ev_strobe[sel_q[i]] && (sel_q[i] != PARK);
      wrap[i] = hit[i] && (&cnt_q[i]) && !ld[i] && !clr_pair;
    end
  end

  assign cyc_wrap = tick && (&cyc_q) && !cyc_ld && !clr_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= 1'b0;
      ie_q  <= '0;
      ovf_q <= '0;
      sel_q <= '0;
    end else begin
      ovf_q <= (ovf_q & ~(ctl_wr ? bus_wdata[10:8] : 3'b000)) | {cyc_wrap, wrap};
      if (ctl_wr) begin
        en_q     <= bus_wdata[0];
        div_q    <= bus_wdata[3];
        ie_q     <= bus_wdata[6:4];
        sel_q[0] <= bus_wdata[27:20];
        sel_q[1] <= bus_wdata[19:12];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (clr_pair)    cnt_q[i] <= '0;
        else if (ld[i])  cnt_q[i] <= bus_wdata[CNT_W-1:0];
        else if (hit[i]) cnt_q[i] <= cnt_q[i] + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      pre_q <= '0;
    end else begin
      if (clr_cyc)     pre_q <= '0;
      else if (en_q)   pre_q <= pre_q + PONE;
      if (clr_cyc)     cyc_q <= '0;
      else if (cyc_ld) cyc_q <= bus_wdata[CNT_W-1:0];
      else if (tick)   cyc_q <= cyc_q + ONE;
    end
  end

  wire [31:0] ctl_word = {4'b0, sel_q[0], sel_q[1], 1'b0, ovf_q, 1'b0, ie_q, div_q, 2'b0, en_q};

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = ctl_word;
      2'd1:    bus_rdata = 32'(cyc_q);
      2'd2:    bus_rdata = 32'(cnt_q[0]);
      default: bus_rdata = 32'(cnt_q[1]);
    endcase
  end

  assign irq = |(ovf_q & ie_q);

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:28], bus_wdata[11], bus_wdata[7]};
endmodule

// File: rtl/evmon_chk.sv
module evmon_chk #(
  parameter int CNT_W = 32,
  parameter logic [7:0] PARK = 8'h20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [1:0]            bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [255:0]          ev_strobe,
  input logic                  irq,
  input logic                  en_q,
  input logic [2:0]            ie_q,
  input logic [2:0]            ovf_q,
  input logic [1:0][7:0]       sel_q,
  input logic [1:0][CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0]      cyc_q
);
  // R2
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !bus_wr) |=> ($stable(cnt_q) && $stable(cyc_q)));

  // R4
  parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[0] == PARK && !bus_wr) |=> $stable(cnt_q[0]));

  // R8
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && ev_strobe[sel_q[0]] && sel_q[0] != PARK && (&cnt_q[0]) && !bus_wr)
    |=> (ovf_q[0] && cnt_q[0] == '0));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[9] && !(&cnt_q[1])) |=> !ovf_q[1]);

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> (cnt_q[1] == $past(bus_wdata[CNT_W-1:0])));

  // R6
  cyc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[2]) |=> (cyc_q == '0));

  // R10
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_q & ie_q) == 3'b000) |-> !irq);
endmodule

bind evmon evmon_chk #(.CNT_W(CNT_W), .PARK(PARK)) chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ev_strobe(ev_strobe), .irq(irq), .en_q(en_q),
  .ie_q(ie_q), .ovf_q(ovf_q), .sel_q(sel_q), .cnt_q(cnt_q), .cyc_q(cyc_q)
);

// File: tb/evmon_test.sv
`timescale 1ns/1ps
module evmon_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [255:0] ev_strobe = '0;
  logic irq;

  evmon uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
             .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_strobe(ev_strobe), .irq(irq));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic m_en, m_div;
  logic [2:0] m_ie, m_ovf;
  logic [7:0] m_sel [2];
  logic [31:0] m_cnt [2];
  logic [31:0] m_cyc;
  logic [5:0] m_pre;

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {4'b0, m_sel[0], m_sel[1], 1'b0, m_ovf, 1'b0, m_ie, m_div, 2'b0, m_en};
      2'd1: return m_cyc;
      2'd2: return m_cnt[0];
      default: return m_cnt[1];
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_step(logic w, logic [1:0] a, logic [31:0] d, logic [255:0] ev);
    logic wc;
    logic [2:0] f;
    logic [31:0] nc [2];
    logic [31:0] ny;
    logic [5:0] np;
    logic tk;
    wc = w && a == 2'd0;
    f = 3'b000;
    for (int i = 0; i < 2; i++) begin
      logic h;
      h = m_en && ev[m_sel[i]] && m_sel[i] != 8'h20;
      nc[i] = m_cnt[i];
      if (wc && d[1]) nc[i] = 0;
      else if (w && a == 2'(2 + i)) nc[i] = d;
      else if (h) begin
        nc[i] = m_cnt[i] + 1;
        if (m_cnt[i] == 32'hFFFF_FFFF) f[i] = 1'b1;
      end
    end
    tk = m_en && (!m_div || m_pre == 6'd63);
    ny = m_cyc;
    if (wc && d[2]) ny = 0;
    else if (w && a == 2'd1) ny = d;
    else if (tk) begin
      ny = m_cyc + 1;
      if (m_cyc == 32'hFFFF_FFFF) f[2] = 1'b1;
    end
    np = (wc && d[2]) ? 6'd0 : (m_en ? m_pre + 6'd1 : m_pre);
    m_ovf = (m_ovf & ~(wc ? d[10:8] : 3'b000)) | f;
    if (wc) begin
      m_en = d[0]; m_div = d[3]; m_ie = d[6:4];
      m_sel[0] = d[27:20]; m_sel[1] = d[19:12];
    end
    m_cnt[0] = nc[0]; m_cnt[1] = nc[1]; m_cyc = ny; m_pre = np;
  endtask

  task automatic drive(logic w, logic [1:0] a, logic [31:0] d, logic [255:0] ev);
    bus_wr = w; bus_addr = a; bus_wdata = d; ev_strobe = ev;
    #1;
    chk("R11 read map", bus_rdata, m_read(a));
    chk("R10 irq", {31'b0, irq}, {31'b0, |(m_ovf & m_ie)});
    m_step(w, a, d, ev);
    @(negedge clk);
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] v);
    bus_wr = 1'b0; bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  function automatic logic [255:0] evb(int k);
    logic [255:0] e;
    e = '0;
    e[k] = 1'b1;
    return e;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c;
    m_en = 0; m_div = 0; m_ie = 0; m_ovf = 0; m_sel[0] = 0; m_sel[1] = 0;
    m_cnt[0] = 0; m_cnt[1] = 0; m_cyc = 0; m_pre = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      chk("R1 reset value", v, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    @(negedge clk);

    // R2 disabled: strobes everywhere, nothing counts
    repeat (5) drive(0, 0, 0, '1);
    peek(2, v); chk("R2 counter0 halted", v, 0);
    peek(1, v); chk("R2 cycle halted", v, 0);

    // R3 event selection, R5 full-rate cycle count
    drive(1, 0, 32'h0050_9001, '0);
    repeat (3) drive(0, 0, 0, evb(5));
    drive(0, 0, 0, evb(9));
    peek(2, v); chk("R3 counter0 events", v, 3);
    peek(3, v); chk("R3 counter1 events", v, 1);
    peek(1, v); chk("R5 cycle full rate", v, 4);

    // R4 parked code
    drive(1, 0, 32'h0200_9001, '0);
    repeat (4) drive(0, 0, 0, evb(32) | evb(5));
    peek(2, v); chk("R4 parked counter", v, 3);

    // R8 wrap and R10 interrupt
    drive(1, 2, 32'hFFFF_FFFE, '0);
    drive(1, 0, 32'h0050_9011, '0);
    repeat (2) drive(0, 0, 0, evb(5));
    peek(2, v); chk("R8 wrapped to zero", v, 0);
    peek(0, v); chk("R8 flag set", v, 32'h0050_9111);
    chk("R10 irq raised", {31'b0, irq}, 1);

    // R12 write back what was read
    peek(0, v);
    drive(1, 0, v, '0);
    peek(0, v); chk("R12 only flag cleared", v, 32'h0050_9011);
    peek(3, v); chk("R12 counters kept", v, 1);
    chk("R12 irq dropped", {31'b0, irq}, 0);

    // R9 writing zero to a flag keeps it
    drive(1, 3, 32'hFFFF_FFFF, '0);
    drive(0, 0, 0, evb(9));
    drive(1, 0, 32'h0050_9011, '0);
    peek(0, v); chk("R9 flag kept on zero", v, 32'h0050_9211);
    chk("R10 masked flag no irq", {31'b0, irq}, 0);
    drive(1, 0, 32'h0050_9031, '0);
    chk("R10 enable raises irq", {31'b0, irq}, 1);

    // R7 write wins over event
    drive(1, 3, 32'h1234_5678, evb(9));
    peek(3, v); chk("R7 write wins", v, 32'h1234_5678);
    peek(0, v); chk("R7 no overflow on load", v, 32'h0050_9231);

    // R6 clear actions
    drive(1, 0, 32'h0050_9033, evb(5) | evb(9));
    peek(2, v); chk("R6 pair cleared c0", v, 0);
    peek(3, v); chk("R6 pair cleared c1", v, 0);
    peek(0, v); chk("R6 action bits read zero", v, 32'h0050_9231);
    drive(1, 0, 32'h0050_9035, '0);
    peek(1, v); chk("R6 cycle cleared", v, 0);

    // R5 divided rate
    drive(1, 0, 32'h0050_903D, '0);
    repeat (191) drive(0, 0, 0, '0);
    peek(1, v); chk("R5 divided before boundary", v, 2);
    drive(0, 0, 0, '0);
    peek(1, v); chk("R5 divided at boundary", v, 3);

    // R11 reserved bits read zero
    drive(1, 0, 32'hFFFF_FFFF, '0);
    peek(0, v); chk("R11 reserved zero", v, 32'h0FFF_F079);

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      logic w;
      logic [1:0] a;
      logic [31:0] d;
      logic [255:0] e;
      w = ($urandom % 4) == 0;
      a = 2'($urandom % 4);
      if (a == 2'd0) begin
        d = $urandom;
        d[0] = ($urandom % 8) != 0;
        d[3] = ($urandom % 4) == 0;
        d[1] = ($urandom % 16) == 0;
        d[2] = ($urandom % 16) == 0;
        case ($urandom % 4)
          0: d[27:20] = 8'h20;
          1: d[27:20] = 8'h05;
          2: d[27:20] = 8'h09;
          default: d[27:20] = 8'($urandom);
        endcase
        case ($urandom % 4)
          0: d[19:12] = 8'h20;
          1: d[19:12] = 8'h09;
          2: d[19:12] = 8'h05;
          default: d[19:12] = 8'($urandom);
        endcase
      end else begin
        d = ($urandom % 2) ? (32'hFFFF_FFF0 + ($urandom % 16)) : $urandom;
      end
      e = '0;
      if ($urandom % 2) e[m_sel[0]] = 1'b1;
      if ($urandom % 2) e[m_sel[1]] = 1'b1;
      if ($urandom % 2) e[32] = 1'b1;
      e[$urandom % 256] = 1'b1;
      drive(w, a, d, e);
    end

    c = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule